// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block collects interrupt events for a small 8-bit processor from three places: a rising edge on an asynchronous external request pin, a one-cycle overflow pulse from a timer, and any change on four upper pins of an I/O port. Each event sets a sticky flag. One control register holds the flags, one enable per source and a global enable.

The block raises a vector request to the CPU while the global enable is set and at least one flag has its enable set. The request carries a fixed vector address of 0004h. When the CPU acknowledges, the block clears the global enable so that no second request can follow at once. The CPU pushes its return address and jumps; the program counter and stack sit outside this block. A return-from-interrupt strobe sets the global enable again. Flags are cleared only by software, through register writes.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset the control register reads 00h and the vector request is low.
- R2: The control register layout is bit 0 external flag, bit 1 timer flag, bit 2 pin-change flag, bit 3 always 0, bit 4 external enable, bit 5 timer enable, bit 6 pin-change enable, bit 7 global enable. A write loads all seven fields from the write data, and the read data returns them at once.
- R3: A rising edge on the external pin sets bit 0 on the third clock edge after the pin changes (two synchroniser stages plus one edge stage). A falling edge sets nothing.
- R4: A timer overflow pulse sets bit 1 on the next clock edge.
- R5: The four port pins pass through a two-stage synchroniser and are compared with the value captured on the last port-read strobe. Any mismatch sets bit 2. After a port read captures the current pins, no further mismatch is seen.
- R6: Flags latch events even when the source enable or the global enable is clear. A pending flag raises the request as soon as both enables are set.
- R7: The vector request is high exactly when the global enable is set and some flag has its enable set. The vector address output is always 0004h.
- R8: An acknowledge clears the global enable, so the request drops in the cycle after the acknowledge.
- R9: No hardware action clears a flag, including an acknowledge. A flag stays set until a register write loads a 0 into it.
- R10: The return strobe sets the global enable. When an acknowledge falls in the same cycle as a return strobe or as a register write, the acknowledge wins and the global enable ends clear.
- R11: When a source event falls in the same cycle as a register write that loads 0 into that source's flag, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| port_hi | input | 4 | Port pins 7:4, asynchronous |
| port_rd | input | 1 | Strobe: CPU reads the port, capture pins |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| vec_ack | input | 1 | CPU accepts the vector request |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_req | output | 1 | Vector request to the CPU |
| vec_addr | output | 16 | Fixed vector address |

## Verification
Two pairs of actions can land in the same cycle: a hardware event and a software write that clears its flag, and an acknowledge together with a return strobe or a write that sets the global enable. The bench provokes each pair by driving the event pulse and the write strobe in the same cycle, and then the acknowledge with the competing strobe. It judges the outcome from the register read-back in the next cycle: the flag must remain set and the global enable must be clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_N   = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_CHG = 2;

    typedef struct packed {
        logic             gie;
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] flg;
    } irqc_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_rise.sv
module irqc_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = s & ~prev_q;

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/irqc_chg_det.sv
module irqc_chg_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s,
    input  logic         port_rd,
    output logic         mismatch
);
    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (port_rd) cap_d = s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign mismatch = |(s ^ cap_q);

    // R5
    chg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && $stable(s)) |=> !mismatch);
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
    parameter int          SYNC_STAGES = 2,
    parameter int          CHG_W       = 4,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] VEC_ADDR    = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              tmr_ovf,
    input  logic [CHG_W-1:0]  port_hi,
    input  logic              port_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              vec_ack,
    input  logic              reti,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr
);
    import irqc_pkg::*;

    localparam int EN_LSB = 4;
    localparam int GIE_B  = 7;

    logic             ext_s;
    logic [CHG_W-1:0] port_s;
    logic             ext_rise;
    logic             chg_hit;
    logic [SRC_N-1:0] evt;

    irqc_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_pin), .dout(ext_s));

    irqc_sync #(.W(CHG_W), .STAGES(SYNC_STAGES)) i_port_sync (
        .clk(clk), .rst_n(rst_n), .din(port_hi), .dout(port_s));

    irqc_rise i_ext_rise (
        .clk(clk), .rst_n(rst_n), .s(ext_s), .rise(ext_rise));

    irqc_chg_det #(.W(CHG_W)) i_chg (
        .clk(clk), .rst_n(rst_n), .s(port_s), .port_rd(port_rd),
        .mismatch(chg_hit));

    always_comb begin
        evt          = '0;
        evt[SRC_EXT] = ext_rise;
        evt[SRC_TMR] = tmr_ovf;
        evt[SRC_CHG] = chg_hit;
    end

    irqc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            st_d.flg = reg_wdata[SRC_N-1:0];
            st_d.en  = reg_wdata[EN_LSB +: SRC_N];
            st_d.gie = reg_wdata[GIE_B];
        end
        st_d.flg = st_d.flg | evt;
        if (reti)    st_d.gie = 1'b1;
        if (vec_ack) st_d.gie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = {st_q.gie, st_q.en, 1'b0, st_q.flg};
    assign vec_req   = st_q.gie & |(st_q.flg & st_q.en);
    assign vec_addr  = VEC_ADDR[ADDR_W-1:0];

    // R8
    ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ack |=> !vec_req);

    // R10
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !vec_ack) |=> reg_rdata[GIE_B]);

    // R4
    tmr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> reg_rdata[SRC_TMR]);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((reg_rdata[SRC_N-1:0] & $past(reg_rdata[SRC_N-1:0]))
                     == $past(reg_rdata[SRC_N-1:0])));
endmodule

// File: tb/test_irqc_ctrl.sv
module test_irqc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0;
    logic        tmr_ovf = 1'b0;
    logic [3:0]  port_hi = 4'h0;
    logic        port_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        vec_ack = 1'b0;
    logic        reti = 1'b0;
    logic        vec_req;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       req;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    irqc_ctrl i_irqc_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_hi(port_hi), .port_rd(port_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_ack(vec_ack),
        .reti(reti), .vec_req(vec_req), .vec_addr(vec_addr));

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (reg_rdata !== e.rd || vec_req !== e.req || vec_addr !== 16'h0004) begin
                errors++;
                $display("FAIL %s: rdata=%h req=%b addr=%h expected rdata=%h req=%b addr=0004",
                         e.tag, reg_rdata, vec_req, vec_addr, e.rd, e.req);
            end
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic expect_st(logic [7:0] rd, logic req, string tag);
        exp_t e;
        e.rd = rd; e.req = req; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        expect_st(8'h00, 1'b0, "R1 during reset");
        cyc();
        rst_n = 1'b1;
        cyc();
        expect_st(8'h00, 1'b0, "R1 after reset");

        wr(8'h70); expect_st(8'h70, 1'b0, "R2 enables write");
        wr(8'h0F); expect_st(8'h07, 1'b0, "R2 flags write, bit3 zero");
        wr(8'h00); expect_st(8'h00, 1'b0, "R2 clear");

        // R4 / R6: timer flag latches with all enables off
        tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
        expect_st(8'h02, 1'b0, "R4 R6 timer flag");
        wr(8'h00);

        // R3: external rising edge, three edges of latency
        ext_pin = 1'b1; cyc(2);
        expect_st(8'h00, 1'b0, "R3 not yet");
        cyc();
        expect_st(8'h01, 1'b0, "R3 rise sets flag");
        wr(8'h00);
        ext_pin = 1'b0; cyc(4);
        expect_st(8'h00, 1'b0, "R3 falling edge ignored");

        // R5: pin change
        port_hi = 4'b1000; cyc(2);
        expect_st(8'h00, 1'b0, "R5 not yet");
        cyc();
        expect_st(8'h04, 1'b0, "R5 change sets flag");
        port_rd = 1'b1; cyc(); port_rd = 1'b0;
        wr(8'h00); cyc(3);
        expect_st(8'h00, 1'b0, "R5 no mismatch after port read");

        // R7 masking and request
        wr(8'hA2); expect_st(8'hA2, 1'b1, "R7 enabled flag requests");
        wr(8'h81); expect_st(8'h81, 1'b0, "R7 flag without enable");
        wr(8'hF0); expect_st(8'hF0, 1'b0, "R7 enables without flag");
        wr(8'h22); expect_st(8'h22, 1'b0, "R7 no global enable");

        // R8 / R9 acknowledge
        wr(8'hA2);
        vec_ack = 1'b1; cyc(); vec_ack = 1'b0;
        expect_st(8'h22, 1'b0, "R8 R9 ack clears gie, keeps flag");
        cyc(2);
        expect_st(8'h22, 1'b0, "R9 flag stays set");

        // R10 return strobe
        reti = 1'b1; cyc(); reti = 1'b0;
        expect_st(8'hA2, 1'b1, "R10 reti sets gie");
        reti = 1'b1; vec_ack = 1'b1; cyc(); reti = 1'b0; vec_ack = 1'b0;
        expect_st(8'h22, 1'b0, "R10 ack wins over reti");
        reg_wr = 1'b1; reg_wdata = 8'hA2; vec_ack = 1'b1; cyc();
        reg_wr = 1'b0; vec_ack = 1'b0;
        expect_st(8'h22, 1'b0, "R10 ack wins over write");

        // R6: pending flag fires once enabled
        wr(8'h20);
        tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
        expect_st(8'h22, 1'b0, "R6 pending with gie clear");
        reti = 1'b1; cyc(); reti = 1'b0;
        expect_st(8'hA2, 1'b1, "R6 pending fires");

        // R11 event and clearing write collide
        reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1; cyc();
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        expect_st(8'h02, 1'b0, "R11 event beats clear");
        wr(8'h00); expect_st(8'h00, 1'b0, "R11 plain clear");

        cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule